// File: doc/BRIEF.md
# Translation Table Pointer Generator

This block forms the memory address of the table entry that software probes after a translation miss. It takes three inputs. The first is the tag value that was captured on the miss, which holds the virtual page and the context. The second is the table base register, which holds the table's base address, a split flag and a size code. The third is a configuration word, which selects the page size in use. From these it builds a 64-bit pointer, aligned to a 16-byte entry, that indexes the in-memory table.

The block is combinational up to one output register. A read strobe loads that register, and on the next clock the pointer appears together with a one-cycle valid pulse. Between strobes the pointer holds its value, whatever the inputs do. Access to the base and configuration registers, and the memory fetch itself, take place elsewhere.

Top module: `tsb_ptr_gen`

## Requirements
- R1: While reset is asserted, and right after it is released, `ptr` reads zero and `ptr_vld` is low.
- R2: `ptr_vld` is high for exactly the cycle after each cycle in which `rd_strobe` was high, and is low in every other cycle.
- R3: Pointer bits 63:13 are base bits 63:13, combined by OR with the index and split bits described below.
- R4: The size code is base bits 3:0. When base bit 12 (the split flag) is 1, pointer bit 13+size is set. When it is 0, that bit comes only from the base.
- R5: The index source is the tag value shifted right by 9 + 3·p, where p is configuration bits 10:8.
- R6: The shifted tag is masked to bits 12+size down to 4 before it is ORed into the pointer.
- R7: Pointer bits 3:0 are always zero.
- R8: When p is 6 or 7, no tag bits enter the pointer. Bits 12:4 are then zero.
- R9: In any cycle after which `rd_strobe` was low, `ptr` keeps its previous value, even if the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_strobe | input | 1 | Loads a new pointer into the output register |
| tag_acc | input | 64 | Tag value: virtual page and context |
| tbl_base | input | 64 | Table base, split flag (bit 12), size code (bits 3:0) |
| cfg_word | input | 64 | Configuration; page-size code in bits 10:8 |
| ptr | output | 64 | Registered table pointer |
| ptr_vld | output | 1 | One-cycle pulse marking a freshly loaded pointer |

## Verification
Base bits 63:13 and the masked tag index can claim the same pointer bits in the same cycle. Those are bits 13 through 12+size, and the two sources meet through OR. The bench provokes this by sending all-ones tags against bases that have scattered bits set in that range. It also uses a large size code with the split flag on, so that the split bit sits just above the top index bit. A behavioural reference forms the pointer by integer shifts and masks, and every cycle it is compared against both the pointer and the valid pulse. Back-to-back strobes, and idle cycles with changing inputs, confirm that loading and holding alternate correctly.

// File: rtl/tsb_ptr_pkg.sv
package tsb_ptr_pkg;
  localparam int unsigned WORD_W      = 64;
  localparam int unsigned SIZE_W      = 4;
  localparam int unsigned PGSZ_W      = 3;
  localparam int unsigned PGSZ_LSB    = 8;
  localparam int unsigned SPLIT_POS   = 12;
  localparam int unsigned BASE_LSB    = 13;
  localparam int unsigned ENTRY_LSB   = 4;
  localparam int unsigned SHIFT_BASE  = 9;
  localparam int unsigned SHIFT_STEP  = 3;
  localparam int unsigned PGSZ_LIMIT  = 5;

  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/tsb_index_extract.sv
module tsb_index_extract #(
  parameter int unsigned AW         = tsb_ptr_pkg::WORD_W,
  parameter int unsigned SZ_W       = tsb_ptr_pkg::SIZE_W,
  parameter int unsigned PS_W       = tsb_ptr_pkg::PGSZ_W,
  parameter int unsigned SHIFT_BASE = tsb_ptr_pkg::SHIFT_BASE,
  parameter int unsigned SHIFT_STEP = tsb_ptr_pkg::SHIFT_STEP,
  parameter int unsigned PS_LIMIT   = tsb_ptr_pkg::PGSZ_LIMIT,
  parameter int unsigned ENTRY_LSB  = tsb_ptr_pkg::ENTRY_LSB,
  parameter int unsigned BASE_LSB   = tsb_ptr_pkg::BASE_LSB
) (
  input  logic [AW-1:0]   tag_in,
  input  logic [PS_W-1:0] pgsz,
  input  logic [SZ_W-1:0] size_code,
  output logic [AW-1:0]   index_out
);
  localparam int unsigned NUM_SHIFTS = PS_LIMIT + 1;

  logic [AW-1:0] shifted [NUM_SHIFTS];
  logic [AW-1:0] picked;
  logic [AW-1:0] keep_mask;

  // One fixed shifter per legal page-size code.
  for (genvar g = 0; g < NUM_SHIFTS; g++) begin : g_shift
    assign shifted[g] = tag_in >> (SHIFT_BASE + SHIFT_STEP * g);
  end

  always_comb begin
    picked = '0;
    for (int k = 0; k < NUM_SHIFTS; k++) begin
      if (int'(pgsz) == k) picked = shifted[k];
    end
  end

  // Keep bits ENTRY_LSB .. BASE_LSB-1+size.
  always_comb begin
    for (int b = 0; b < AW; b++) begin
      keep_mask[b] = (b >= ENTRY_LSB) && (b < BASE_LSB + int'(size_code));
    end
  end

  assign index_out = picked & keep_mask;
endmodule

// File: rtl/tsb_base_compose.sv
module tsb_base_compose #(
  parameter int unsigned AW        = tsb_ptr_pkg::WORD_W,
  parameter int unsigned SZ_W      = tsb_ptr_pkg::SIZE_W,
  parameter int unsigned SPLIT_POS = tsb_ptr_pkg::SPLIT_POS,
  parameter int unsigned BASE_LSB  = tsb_ptr_pkg::BASE_LSB
) (
  input  logic [AW-1:0]   base_in,
  output logic [SZ_W-1:0] size_code,
  output logic [AW-1:0]   base_part
);
  logic [AW-1:0] upper;
  logic [AW-1:0] split_bit;

  assign size_code = base_in[SZ_W-1:0];
  assign upper     = {base_in[AW-1:BASE_LSB], {BASE_LSB{1'b0}}};

  always_comb begin
    split_bit = '0;
    if (base_in[SPLIT_POS]) split_bit = AW'(1) << (BASE_LSB + int'(size_code));
  end

  assign base_part = upper | split_bit;
endmodule

// File: rtl/tsb_ptr_gen.sv
module tsb_ptr_gen #(
  parameter int unsigned AW       = tsb_ptr_pkg::WORD_W,
  parameter int unsigned SZ_W     = tsb_ptr_pkg::SIZE_W,
  parameter int unsigned PS_W     = tsb_ptr_pkg::PGSZ_W,
  parameter int unsigned PS_LSB   = tsb_ptr_pkg::PGSZ_LSB,
  parameter int unsigned PS_LIMIT = tsb_ptr_pkg::PGSZ_LIMIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_strobe,
  input  logic [AW-1:0] tag_acc,
  input  logic [AW-1:0] tbl_base,
  input  logic [AW-1:0] cfg_word,
  output logic [AW-1:0] ptr,
  output logic          ptr_vld
);
  localparam int unsigned PS_MSB = PS_LSB + PS_W - 1;

  logic [1:0]      rst_sync_q;
  logic            rst_ok;
  logic [PS_W-1:0] pgsz;
  logic [SZ_W-1:0] size_code;
  logic [AW-1:0]   base_part;
  logic [AW-1:0]   index_part;
  logic [AW-1:0]   ptr_d;
  logic            vld_d;
  logic [AW-1:0]   ptr_q;
  logic            vld_q;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  assign pgsz = cfg_word[PS_MSB:PS_LSB];

  tsb_base_compose #(
    .AW(AW), .SZ_W(SZ_W)
  ) u_base (
    .base_in   (tbl_base),
    .size_code (size_code),
    .base_part (base_part)
  );

  tsb_index_extract #(
    .AW(AW), .SZ_W(SZ_W), .PS_W(PS_W), .PS_LIMIT(PS_LIMIT)
  ) u_index (
    .tag_in    (tag_acc),
    .pgsz      (pgsz),
    .size_code (size_code),
    .index_out (index_part)
  );

  // Next state
  always_comb begin
    ptr_d = ptr_q;
    vld_d = rd_strobe;
    if (rd_strobe) ptr_d = base_part | index_part;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      ptr_q <= '0;
      vld_q <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      vld_q <= vld_d;
    end
  end

  assign ptr     = ptr_q;
  assign ptr_vld = vld_q;
endmodule

// File: rtl/tsb_ptr_gen_chk.sv
module tsb_ptr_gen_chk #(
  parameter int unsigned AW       = 64,
  parameter int unsigned PS_W     = 3,
  parameter int unsigned PS_LIMIT = 5
) (
  input logic            clk,
  input logic            rst_ok,
  input logic            rd_strobe,
  input logic [PS_W-1:0] pgsz,
  input logic [AW-1:0]   ptr,
  input logic            ptr_vld
);
  assert_vld_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    rd_strobe |=> ptr_vld);

  assert_vld_needs_strobe_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    ptr_vld |-> $past(rd_strobe));

  assert_entry_aligned_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    ptr[3:0] == 4'h0);

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    !rd_strobe |=> $stable(ptr));

  assert_no_index_big_page_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (rd_strobe && (int'(pgsz) > PS_LIMIT)) |=> (ptr[12:4] == 9'h0));
endmodule

bind tsb_ptr_gen tsb_ptr_gen_chk #(
  .AW(AW), .PS_W(PS_W), .PS_LIMIT(PS_LIMIT)
) u_chk (
  .clk       (clk),
  .rst_ok    (rst_ok),
  .rd_strobe (rd_strobe),
  .pgsz      (pgsz),
  .ptr       (ptr),
  .ptr_vld   (ptr_vld)
);

// File: tb/tb_tsb_ptr_gen.sv
module tb_tsb_ptr_gen;
  logic        clk;
  logic        rst_n;
  logic        rd_strobe;
  logic [63:0] tag_acc;
  logic [63:0] tbl_base;
  logic [63:0] cfg_word;
  logic [63:0] ptr;
  logic        ptr_vld;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic        done = 1'b0;
  logic [63:0] exp_ptr = '0;
  logic        exp_vld = 1'b0;

  tsb_ptr_gen dut (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe),
    .tag_acc(tag_acc), .tbl_base(tbl_base), .cfg_word(cfg_word),
    .ptr(ptr), .ptr_vld(ptr_vld)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Behavioural reference: integer shift and mask arithmetic.
  function automatic logic [63:0] model(input logic [63:0] t, input logic [63:0] b,
                                        input logic [63:0] c);
    int unsigned sz = b[3:0];
    int unsigned p  = c[10:8];
    logic [63:0] r;
    logic [63:0] m;
    r = b & ~64'h1FFF;
    if (b[12]) r = r | (64'd1 << (13 + sz));
    if (p <= 5) begin
      m = ((64'd1 << (13 + sz)) - 64'd1) & ~64'hF;
      r = r | ((t >> (9 + 3 * p)) & m);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at negedge, let one posedge pass, compare at the next negedge.
  task automatic step(input string req, input logic s, input logic [63:0] t,
                      input logic [63:0] b, input logic [63:0] c);
    rd_strobe = s; tag_acc = t; tbl_base = b; cfg_word = c;
    @(posedge clk);
    exp_vld = s;
    if (s) exp_ptr = model(t, b, c);
    @(negedge clk);
    check({req, " ptr"}, ptr, exp_ptr);
    check("R2 vld", {63'd0, ptr_vld}, {63'd0, exp_vld});
  endtask

  initial begin
    rst_n = 1'b0; rd_strobe = 1'b0;
    tag_acc = '0; tbl_base = '0; cfg_word = '0;
    repeat (3) @(negedge clk);
    check("R1 ptr in reset", ptr, 64'd0);
    check("R1 vld in reset", {63'd0, ptr_vld}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ptr after release", ptr, 64'd0);
    check("R1 vld after release", {63'd0, ptr_vld}, 64'd0);

    step("R3 base only", 1'b1, 64'd0, 64'hDEAD_BEEF_CAFE_F00D, 64'd0);
    step("R9 idle", 1'b0, '1, 64'h1234_5678_9ABC_DEF0, 64'h700);
    step("R6 R7 all-ones tag size0", 1'b1, '1, 64'd0, 64'd0);
    step("R4 split size0", 1'b1, 64'd0, 64'h0000_0000_0000_1000, 64'd0);
    step("R4 split size15", 1'b1, '1, 64'h0000_0000_0000_100F, 64'd0);
    step("R4 no split size15", 1'b1, 64'd0, 64'h0000_0000_0000_000F, 64'd0);
    for (int p = 0; p < 6; p++) begin
      step("R5 page size", 1'b1, 64'hA5C3_96F0_1E2D_3C4B, 64'h0000_0000_0000_0007,
           64'(p) << 8);
    end
    step("R8 page code 6", 1'b1, '1, 64'h0000_0000_0000_0005, 64'h600);
    step("R8 page code 7", 1'b1, '1, 64'h0000_0000_0000_0003, 64'h700);
    step("R3 overlap base/index", 1'b1, '1, 64'hF0F0_0000_00AA_A00A, 64'h100);
    step("R3 overlap split", 1'b1, 64'h5555_5555_5555_5555, 64'h0F00_0000_0555_700C,
         64'hFFFF_FFFF_FFFF_F2FF);
    step("R9 hold 1", 1'b0, 64'h1111, 64'h2222_0000, 64'h300);
    step("R9 hold 2", 1'b0, '1, '1, '1);
    step("R2 burst a", 1'b1, 64'h0123_4567_89AB_CDEF, 64'h0000_4000_0000_2004, 64'h200);
    step("R2 burst b", 1'b1, 64'hFEDC_BA98_7654_3210, 64'h0000_8000_0000_300A, 64'h400);
    step("R2 burst c", 1'b1, 64'h0F0F_0F0F_0F0F_0F0F, 64'h0000_0000_0001_0001, 64'h500);
    step("R2 after burst", 1'b0, '0, '0, '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule